// File: doc/BRIEF.md
# SIMD Lane-Mask Divergence Stack

This block is the per-wavefront control unit that lets a 64-lane SIMD engine run structured if/else/endif code when its lanes disagree. A sequencer sends it one command at a time, each carrying a 64-bit per-lane condition vector produced by vector compares. The block holds the active-lane mask and a last-in first-out stack of saved lane sets, with one word per nesting level. Lanes whose mask bit is clear do no work.

Each branch command updates the mask with plain AND, XOR and OR arithmetic on the mask and the top stack word. A registered all-zero flag lets the sequencer skip a region in which no lane is live. The narrow command clears lanes from the mask outside the branch structure, as a per-lane discard would. When a pixel wavefront leaves its outermost endif with no live lanes, the block first requests a null-target export and then requests termination. After that it refuses further commands until reset. Stack overflow and underflow set a sticky error flag and are otherwise ignored.

Commands use a valid/ready handshake. A command is taken on a rising clock edge only when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high whenever the wavefront is running and low from the export request onward. The sequencer must hold the command stable while ready is low. Every output comes from a register and shows the effect of a command in the cycle after the edge that took it.

Top module: `lane_mask_stack`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets the mask to all ones, the depth to 0, and `exec_zero`, `stack_err`, `export_null` and `terminate` to 0. It sets `cmd_ready` to 1.
- R2: IF (`cmd_op`=2'b01) with depth below DEPTH sets the mask to mask AND cond. It pushes the word (old mask XOR new mask), which holds the live lanes that failed the condition, and raises the depth by one.
- R3: ELSE (`cmd_op`=2'b10) with depth above 0 sets the mask to (top OR mask) XOR mask, so that exactly the stacked lanes become active. It overwrites the top word with the then-path mask, and the depth is unchanged.
- R4: ENDIF (`cmd_op`=2'b11) with depth above 0 sets the mask to mask OR top, pops the top word, and lowers the depth by one.
- R5: NARROW (`cmd_op`=2'b00) sets the mask to mask AND cond and leaves the stack and the depth unchanged.
- R6: `exec_zero` is high exactly when the registered mask is all zero, and it updates in the same cycle as the mask.
- R7: IF at depth DEPTH, or ELSE or ENDIF at depth 0, sets `stack_err`. It leaves the mask and the depth unchanged. `stack_err` stays set until reset.
- R8: In pixel mode (`pixel_mode`=1), an ENDIF that leaves the depth at 0 with an all-zero mask raises `export_null` for one cycle, together with the new mask. `terminate` rises for one cycle on the next cycle, and `cmd_ready` stays low from the export cycle until reset. No such request occurs in non-pixel mode, with a nonzero mask, or at an inner ENDIF.
- R9: A command is taken only when `cmd_valid` and `cmd_ready` are both high at a rising edge. Otherwise the mask and the depth do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pixel_mode | input | 1 | Wavefront is a pixel wavefront |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The block can take a command |
| cmd_op | input | 2 | 00 narrow, 01 if, 10 else, 11 endif |
| cmd_cond | input | LANES | Per-lane condition vector |
| exec_mask | output | LANES | Active-lane mask |
| depth | output | $clog2(DEPTH+1) | Number of stacked words |
| exec_zero | output | 1 | Mask is all zero |
| export_null | output | 1 | Null-target export request |
| terminate | output | 1 | Terminate-wavefront request |
| stack_err | output | 1 | Sticky overflow or underflow flag |

## Verification
The checker watches several properties on every cycle. It checks that IF narrows the mask to mask AND cond and deepens the stack, and that ENDIF only adds lanes and pops one level. It checks that a refused overflow changes neither the mask nor the depth, and that the error flag stays set. It also checks that idle cycles hold state, that the zero flag tracks the mask, and that the export request is followed by termination while ready stays low. Only the bench scenarios can show that nested IF/ELSE/ENDIF sequences restore the exact lane sets saved many commands earlier, that ELSE activates precisely the complementary lanes, and that termination happens only in pixel mode at the outermost level.

// File: rtl/lms_pkg.sv
package lms_pkg;
  typedef enum logic [1:0] {
    OP_NARROW = 2'b00,
    OP_IF     = 2'b01,
    OP_ELSE   = 2'b10,
    OP_ENDIF  = 2'b11
  } mop_e;

  typedef enum logic [1:0] {
    WS_RUN    = 2'b00,
    WS_EXPORT = 2'b01,
    WS_TERM   = 2'b10,
    WS_DONE   = 2'b11
  } wstate_e;
endpackage

// File: rtl/mask_lifo.sv
module mask_lifo #(
  parameter int W = 64,
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic          wr_top,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  top,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [IW-1:0] top_idx;
  logic [IW-1:0] wr_idx;
  logic          we;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign top_idx = IW'(count - CW'(1));
  assign wr_idx  = push ? IW'(count) : top_idx;
  assign we      = (push && !full) || (wr_top && !empty);
  assign top     = empty ? '0 : mem[top_idx];

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    always_ff @(posedge clk) begin
      if (we && (wr_idx == IW'(g))) mem[g] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (push && !full) count <= count + CW'(1);
    else if (pop && !empty) count <= count - CW'(1);
  end
endmodule

// File: rtl/mask_step.sv
module mask_step
  import lms_pkg::*;
#(
  parameter int LANES = 64
) (
  input  logic             take,
  input  mop_e             op,
  input  logic [LANES-1:0] mask,
  input  logic [LANES-1:0] cond,
  input  logic [LANES-1:0] top,
  input  logic             full,
  input  logic             empty,
  output logic [LANES-1:0] nxt_mask,
  output logic [LANES-1:0] wdata,
  output logic             push,
  output logic             pop,
  output logic             wr_top,
  output logic             bad
);
  logic [LANES-1:0] narrowed;

  always_comb begin
    nxt_mask = mask;
    wdata    = '0;
    push     = 1'b0;
    pop      = 1'b0;
    wr_top   = 1'b0;
    bad      = 1'b0;
    narrowed = mask & cond;
    if (take) begin
      unique case (op)
        OP_NARROW: nxt_mask = narrowed;
        OP_IF: begin
          if (full) bad = 1'b1;
          else begin
            nxt_mask = narrowed;
            wdata    = mask ^ narrowed;
            push     = 1'b1;
          end
        end
        OP_ELSE: begin
          if (empty) bad = 1'b1;
          else begin
            nxt_mask = (top | mask) ^ mask;
            wdata    = mask;
            wr_top   = 1'b1;
          end
        end
        OP_ENDIF: begin
          if (empty) bad = 1'b1;
          else begin
            nxt_mask = mask | top;
            pop      = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/wave_end_seq.sv
module wave_end_seq
  import lms_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic export_null,
  output logic terminate,
  output logic running
);
  wstate_e st;

  always_ff @(posedge clk) begin
    if (rst) st <= WS_RUN;
    else begin
      unique case (st)
        WS_RUN:    if (fire) st <= WS_EXPORT;
        WS_EXPORT: st <= WS_TERM;
        WS_TERM:   st <= WS_DONE;
        default:   st <= WS_DONE;
      endcase
    end
  end

  assign export_null = (st == WS_EXPORT);
  assign terminate   = (st == WS_TERM);
  assign running     = (st == WS_RUN);
endmodule

// File: rtl/lane_mask_stack.sv
module lane_mask_stack
  import lms_pkg::*;
#(
  parameter int LANES = 64,
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pixel_mode,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [LANES-1:0] cmd_cond,
  output logic [LANES-1:0] exec_mask,
  output logic [CW-1:0]    depth,
  output logic             exec_zero,
  output logic             export_null,
  output logic             terminate,
  output logic             stack_err
);
  mop_e             op;
  logic             take;
  logic [LANES-1:0] mask_q;
  logic [LANES-1:0] nxt_mask;
  logic [LANES-1:0] wdata;
  logic [LANES-1:0] top;
  logic             push, pop, wr_top, bad;
  logic             full, empty;
  logic             zero_q, err_q;
  logic             running;
  logic             fire;

  assign op   = mop_e'(cmd_op);
  assign take = cmd_valid && running;

  mask_step #(.LANES(LANES)) u_step (
    .take(take), .op(op), .mask(mask_q), .cond(cmd_cond), .top(top),
    .full(full), .empty(empty), .nxt_mask(nxt_mask), .wdata(wdata),
    .push(push), .pop(pop), .wr_top(wr_top), .bad(bad)
  );

  mask_lifo #(.W(LANES), .DEPTH(DEPTH)) u_lifo (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .wr_top(wr_top),
    .din(wdata), .top(top), .count(depth), .full(full), .empty(empty)
  );

  // outermost endif in a pixel wavefront that leaves no live lane
  assign fire = pop && pixel_mode && (depth == CW'(1)) && (nxt_mask == '0);

  wave_end_seq u_end (
    .clk(clk), .rst(rst), .fire(fire),
    .export_null(export_null), .terminate(terminate), .running(running)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      zero_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      mask_q <= nxt_mask;
      zero_q <= (nxt_mask == '0);
      if (bad) err_q <= 1'b1;
    end
  end

  assign exec_mask = mask_q;
  assign exec_zero = zero_q;
  assign stack_err = err_q;
  assign cmd_ready = running;
endmodule

// File: rtl/lms_checker.sv
module lms_checker #(
  parameter int LANES = 64,
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [1:0]       cmd_op,
  input logic [LANES-1:0] cmd_cond,
  input logic [LANES-1:0] exec_mask,
  input logic [CW-1:0]    depth,
  input logic             exec_zero,
  input logic             export_null,
  input logic             terminate,
  input logic             stack_err
);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  a_r2_if_narrows: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op == 2'b01 && depth != CW'(DEPTH)) |=>
      (exec_mask == $past(exec_mask & cmd_cond)) && (depth == $past(depth) + CW'(1)));

  a_r4_endif_restores: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op == 2'b11 && depth != '0) |=>
      ((exec_mask & $past(exec_mask)) == $past(exec_mask)) && (depth == $past(depth) - CW'(1)));

  a_r6_zero_flag: assert property (@(posedge clk) disable iff (rst)
    exec_zero == (exec_mask == '0));

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op == 2'b01 && depth == CW'(DEPTH)) |=>
      $stable(exec_mask) && $stable(depth) && stack_err);

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
    stack_err |=> stack_err);

  a_r8_export_then_term: assert property (@(posedge clk) disable iff (rst)
    export_null |=> terminate);

  a_r8_one_request: assert property (@(posedge clk) disable iff (rst)
    $onehot0({export_null, terminate}));

  a_r8_ready_low: assert property (@(posedge clk) disable iff (rst)
    (export_null || terminate) |-> !cmd_ready);

  a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !acc |=> $stable(exec_mask) && $stable(depth));
endmodule

bind lane_mask_stack lms_checker #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_lane_mask_stack.sv
module sim_lane_mask_stack;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 64;
  localparam int DEPTH = 8;
  localparam int CW = $clog2(DEPTH + 1);

  localparam logic [1:0] NAR = 2'b00, IFC = 2'b01, ELS = 2'b10, ENDC = 2'b11;
  localparam logic [63:0] ONES = {64{1'b1}};

  // {op, cond, expected mask, expected depth}
  localparam int NV = 9;
  localparam logic [133:0] VEC [NV] = '{
    {IFC,  64'h0000_FFFF_0000_FFFF, 64'h0000_FFFF_0000_FFFF, 4'd1},
    {IFC,  64'h00FF_00FF_00FF_00FF, 64'h0000_00FF_0000_00FF, 4'd2},
    {ELS,  64'h0,                   64'h0000_FF00_0000_FF00, 4'd2},
    {ENDC, 64'h0,                   64'h0000_FFFF_0000_FFFF, 4'd1},
    {ELS,  64'h0,                   64'hFFFF_0000_FFFF_0000, 4'd1},
    {NAR,  64'hFFFF_FFFF_0000_0000, 64'hFFFF_0000_0000_0000, 4'd1},
    {ENDC, 64'h0,                   64'hFFFF_FFFF_0000_FFFF, 4'd0},
    {IFC,  64'h0,                   64'h0,                   4'd1},
    {ENDC, 64'h0,                   64'hFFFF_FFFF_0000_FFFF, 4'd0}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             pixel_mode = 1'b0;
  logic             cmd_valid = 1'b0;
  logic             cmd_ready;
  logic [1:0]       cmd_op = 2'b00;
  logic [LANES-1:0] cmd_cond = '0;
  logic [LANES-1:0] exec_mask;
  logic [CW-1:0]    depth;
  logic             exec_zero, export_null, terminate, stack_err;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lane_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .pixel_mode(pixel_mode), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_cond(cmd_cond),
    .exec_mask(exec_mask), .depth(depth), .exec_zero(exec_zero),
    .export_null(export_null), .terminate(terminate), .stack_err(stack_err)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    cmd_valid = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic issue(input logic v, input logic [1:0] op, input logic [63:0] c);
    @(negedge clk);
    cmd_valid = v;
    cmd_op = op;
    cmd_cond = c;
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired, all requirements: actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 mask", exec_mask, ONES);
    check("R1 depth", 64'(depth), 64'd0);
    check("R1 flags", {60'd0, exec_zero, stack_err, export_null, terminate}, 64'd0);
    check("R1 ready", 64'(cmd_ready), 64'd1);

    // R2 R3 R4 R5 R6: vector table
    for (int i = 0; i < NV; i++) begin
      issue(1'b1, VEC[i][133:132], VEC[i][131:68]);
      check($sformatf("R2/R3/R4/R5 vec%0d mask", i), exec_mask, VEC[i][67:4]);
      check($sformatf("R2/R3/R4/R5 vec%0d depth", i), 64'(depth), 64'(VEC[i][3:0]));
      check($sformatf("R6 vec%0d zero", i), 64'(exec_zero), 64'(VEC[i][67:4] == 64'h0));
    end
    check("R7 no error after balanced nesting", 64'(stack_err), 64'd0);

    // R9: no valid, nothing changes
    issue(1'b0, IFC, 64'h0);
    check("R9 idle mask", exec_mask, 64'hFFFF_FFFF_0000_FFFF);
    check("R9 idle depth", 64'(depth), 64'd0);

    // R7 underflow and stickiness
    do_reset();
    issue(1'b1, ELS, 64'h0);
    check("R7 else underflow err", 64'(stack_err), 64'd1);
    check("R7 else underflow mask", exec_mask, ONES);
    issue(1'b1, ENDC, 64'h0);
    check("R7 endif underflow depth", 64'(depth), 64'd0);
    issue(1'b1, IFC, 64'h0F);
    check("R7 err sticky", 64'(stack_err), 64'd1);
    check("R2 if after err", exec_mask, 64'h0F);

    // R7 overflow
    do_reset();
    for (int i = 0; i < DEPTH; i++) issue(1'b1, IFC, ONES);
    check("R2 full depth", 64'(depth), 64'(DEPTH));
    check("R7 no err at full", 64'(stack_err), 64'd0);
    issue(1'b1, IFC, 64'h0);
    check("R7 overflow mask", exec_mask, ONES);
    check("R7 overflow depth", 64'(depth), 64'(DEPTH));
    check("R7 overflow err", 64'(stack_err), 64'd1);

    // R8 pixel kill at outermost endif
    do_reset();
    pixel_mode = 1'b1;
    issue(1'b1, NAR, 64'h0);
    check("R5 narrow to zero", exec_mask, 64'h0);
    check("R6 zero flag", 64'(exec_zero), 64'd1);
    issue(1'b1, IFC, ONES);
    issue(1'b1, IFC, ONES);
    issue(1'b1, ENDC, 64'h0);
    check("R8 inner endif no export", 64'(export_null), 64'd0);
    issue(1'b1, ENDC, 64'h0);
    check("R8 export raised", 64'(export_null), 64'd1);
    check("R8 no terminate yet", 64'(terminate), 64'd0);
    check("R8 ready low", 64'(cmd_ready), 64'd0);
    @(posedge clk); #1;
    check("R8 terminate", 64'(terminate), 64'd1);
    check("R8 export dropped", 64'(export_null), 64'd0);
    @(posedge clk); #1;
    check("R8 terminate pulse", 64'(terminate), 64'd0);
    check("R8 ready stays low", 64'(cmd_ready), 64'd0);
    issue(1'b1, IFC, ONES);
    check("R9 refused after terminate", 64'(depth), 64'd0);

    // R8 pixel mode with live lanes
    do_reset();
    issue(1'b1, IFC, 64'h0);
    issue(1'b1, ENDC, 64'h0);
    check("R8 live lanes no export", 64'(export_null), 64'd0);
    check("R4 restore all", exec_mask, ONES);

    // R8 non-pixel mode
    do_reset();
    pixel_mode = 1'b0;
    issue(1'b1, NAR, 64'h0);
    issue(1'b1, IFC, ONES);
    issue(1'b1, ENDC, 64'h0);
    check("R8 non-pixel no export", 64'(export_null), 64'd0);
    @(posedge clk); #1;
    check("R8 non-pixel no terminate", 64'(terminate), 64'd0);
    check("R8 non-pixel ready", 64'(cmd_ready), 64'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule